// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block makes the interlock decisions for an in-order pipeline with five stages: fetch (IF), register read (RF), execute (ALU), memory (MEM) and write-back (WB). Each cycle it looks at the two source register numbers of the instruction sitting in RF and at the destination of each instruction further down the pipe. For each operand it picks where the value comes from: the register file, or a bypass from ALU, MEM or WB. When an operand needs the result of a load that has not yet reached WB, it raises a stall that freezes IF and RF. In the same cycle it turns the slot entering ALU into a bubble.

A taken branch is resolved in RF. The controller then squashes the instruction being fetched behind it, which is the delay slot. The controller keeps its own validity bit for each of the RF, ALU, MEM and WB stages, driven only by its own stall and annul decisions. The surrounding datapath therefore only reports the destination, write enable and load flag of each stage. Register 31 is a hard-wired zero and never creates a dependency.

Top module: `hazard_ctrl`

## Requirements
- R1: Each operand select uses the code 0 for register file, 1 for the ALU-stage bypass, 2 for the MEM-stage bypass and 3 for the WB-stage bypass. The select picks a stage whose destination equals the operand's register number, and chooses the register file when no stage matches.
- R2: When several stages match one operand, the youngest wins: ALU before MEM before WB.
- R3: A load result is forwarded only from WB. When an operand's youngest match is a load in ALU or MEM, the controller raises the stall (if RF is valid) and drives that operand's select to 0.
- R4: Register 31 never matches. A source of 31 always selects 0, and a stage writing register 31 is never a bypass source and never causes a stall.
- R5: A stage is a producer only when its tracked validity bit is set and its write enable is high. Write enables on invalid stages have no effect on the selects or the stall.
- R6: The stall is raised only when RF holds a valid instruction. The RF annul equals the stall, so a bubble (invalid slot) enters ALU in the next cycle while the RF instruction is held.
- R7: The IF annul is high when RF holds a valid instruction, the branch-taken input is high and there is no stall. The instruction that enters RF on the next edge is then invalid.
- R8: The ALU annul output is always low.
- R9: After reset, all tracked stages are invalid, so no select is non-zero and no stall or annul is raised until valid instructions arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rf_src_a | input | 5 | First source register of the RF instruction |
| rf_src_b | input | 5 | Second source register of the RF instruction |
| rf_br_taken | input | 1 | RF instruction is a branch resolved as taken |
| alu_dst | input | 5 | Destination register of the ALU-stage instruction |
| alu_we | input | 1 | ALU-stage instruction writes a register |
| alu_ld | input | 1 | ALU-stage instruction is a load |
| mem_dst | input | 5 | Destination register of the MEM-stage instruction |
| mem_we | input | 1 | MEM-stage instruction writes a register |
| mem_ld | input | 1 | MEM-stage instruction is a load |
| wb_dst | input | 5 | Destination register of the WB-stage instruction |
| wb_we | input | 1 | WB-stage instruction writes a register |
| fwd_sel_a | output | 2 | Source select for operand A |
| fwd_sel_b | output | 2 | Source select for operand B |
| stall | output | 1 | Hold IF and RF this cycle |
| annul_if | output | 1 | Squash the instruction in IF |
| annul_rf | output | 1 | Replace the RF instruction with a bubble into ALU |
| annul_alu | output | 1 | ALU-stage squash, held low |

## Verification
A directed program replays a load, increment, compare and branch loop. It shows the load-use stall with its bubble, a cycle where one operand comes from WB and the other from MEM, a next-cycle bypass from ALU into a branch, and the squash of the delay slot. After that, a random instruction stream draws register numbers from a small set that includes register 31. This produces multi-stage matches that separate the priority order, load hazards in ALU versus MEM, and the zero register rule. Because the bench drives garbage fields into bubbles and squashed slots, the same stream also exposes any use of an invalid stage as a producer.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_ALU = 2'd1,
        FWD_MEM = 2'd2,
        FWD_WB  = 2'd3
    } fwd_sel_e;

    typedef struct packed {
        logic rf;
        logic alu;
        logic mem;
        logic wb;
    } stage_vld_t;

endpackage

// File: rtl/hz_stage_track.sv
module hz_stage_track
    import hz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    input  logic annul_if,
    output logic rf_vld,
    output logic alu_vld,
    output logic mem_vld,
    output logic wb_vld
);

    stage_vld_t vld_d, vld_q;

    always_comb begin
        vld_d     = vld_q;
        vld_d.wb  = vld_q.mem;
        vld_d.mem = vld_q.alu;
        vld_d.alu = vld_q.rf & ~stall;
        if (!stall) begin
            vld_d.rf = ~annul_if;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
    end

    assign rf_vld  = vld_q.rf;
    assign alu_vld = vld_q.alu;
    assign mem_vld = vld_q.mem;
    assign wb_vld  = vld_q.wb;

    // R6
    bubble_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !alu_vld);

    // R6
    rf_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> rf_vld);

    // R7
    slot_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        annul_if |=> !rf_vld);

    // R5
    shift_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_vld |=> mem_vld);

endmodule

// File: rtl/hz_operand_fwd.sv
module hz_operand_fwd
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             alu_ok,
    input  logic [REG_W-1:0] alu_dst,
    input  logic             alu_ld,
    input  logic             mem_ok,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_ld,
    input  logic             wb_ok,
    input  logic [REG_W-1:0] wb_dst,
    output fwd_sel_e         sel,
    output logic             load_haz
);

    localparam logic [REG_W-1:0] ZERO_REG = '1;

    logic src_live;
    logic hit_alu, hit_mem, hit_wb;

    always_comb begin
        src_live = (src != ZERO_REG);
        hit_alu  = src_live & alu_ok & (src == alu_dst);
        hit_mem  = src_live & mem_ok & (src == mem_dst);
        hit_wb   = src_live & wb_ok  & (src == wb_dst);
        sel      = FWD_RF;
        load_haz = 1'b0;
        if (hit_alu) begin
            if (alu_ld) load_haz = 1'b1;
            else        sel      = FWD_ALU;
        end else if (hit_mem) begin
            if (mem_ld) load_haz = 1'b1;
            else        sel      = FWD_MEM;
        end else if (hit_wb) begin
            sel = FWD_WB;
        end
    end

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] rf_src_a,
    input  logic [REG_W-1:0] rf_src_b,
    input  logic             rf_br_taken,
    input  logic [REG_W-1:0] alu_dst,
    input  logic             alu_we,
    input  logic             alu_ld,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_we,
    input  logic             mem_ld,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_we,
    output logic [1:0]       fwd_sel_a,
    output logic [1:0]       fwd_sel_b,
    output logic             stall,
    output logic             annul_if,
    output logic             annul_rf,
    output logic             annul_alu
);

    localparam int               NUM_SRC  = 2;
    localparam logic [REG_W-1:0] ZERO_REG = '1;

    logic rf_vld, alu_vld, mem_vld, wb_vld;
    logic alu_ok, mem_ok, wb_ok;

    logic [REG_W-1:0] src_arr [NUM_SRC];
    fwd_sel_e         sel_arr [NUM_SRC];
    logic [NUM_SRC-1:0] haz_vec;

    hz_stage_track u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall    (stall),
        .annul_if (annul_if),
        .rf_vld   (rf_vld),
        .alu_vld  (alu_vld),
        .mem_vld  (mem_vld),
        .wb_vld   (wb_vld)
    );

    assign alu_ok = alu_vld & alu_we & (alu_dst != ZERO_REG);
    assign mem_ok = mem_vld & mem_we & (mem_dst != ZERO_REG);
    assign wb_ok  = wb_vld  & wb_we  & (wb_dst  != ZERO_REG);

    assign src_arr[0] = rf_src_a;
    assign src_arr[1] = rf_src_b;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_op
        hz_operand_fwd #(.REG_W(REG_W)) u_op (
            .src      (src_arr[g]),
            .alu_ok   (alu_ok),
            .alu_dst  (alu_dst),
            .alu_ld   (alu_ld),
            .mem_ok   (mem_ok),
            .mem_dst  (mem_dst),
            .mem_ld   (mem_ld),
            .wb_ok    (wb_ok),
            .wb_dst   (wb_dst),
            .sel      (sel_arr[g]),
            .load_haz (haz_vec[g])
        );

        // R3
        no_early_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_arr[g] == FWD_ALU) |-> !alu_ld);

        // R4
        zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (src_arr[g] == ZERO_REG) |-> (sel_arr[g] == FWD_RF));

        // R5
        valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_arr[g] == FWD_MEM) |-> mem_vld);
    end

    assign stall     = rf_vld & (|haz_vec);
    assign annul_rf  = stall;
    assign annul_if  = rf_vld & rf_br_taken & ~stall;
    assign annul_alu = 1'b0;
    assign fwd_sel_a = sel_arr[0];
    assign fwd_sel_b = sel_arr[1];

    // R6
    stall_needs_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> rf_vld);

endmodule

// File: tb/hazard_ctrl_tb.sv
module hazard_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYC   = 3000;

    typedef struct {
        logic [4:0] sa, sb, dst;
        logic       we, ld, br;
        logic [3:0] tgt;
    } ins_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] rf_src_a, rf_src_b, alu_dst, mem_dst, wb_dst;
    logic       rf_br_taken, alu_we, alu_ld, mem_we, mem_ld, wb_we;
    logic [1:0] fwd_sel_a, fwd_sel_b;
    logic       stall, annul_if, annul_rf, annul_alu;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hazard_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .rf_src_a(rf_src_a), .rf_src_b(rf_src_b), .rf_br_taken(rf_br_taken),
        .alu_dst(alu_dst), .alu_we(alu_we), .alu_ld(alu_ld),
        .mem_dst(mem_dst), .mem_we(mem_we), .mem_ld(mem_ld),
        .wb_dst(wb_dst), .wb_we(wb_we),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .stall(stall),
        .annul_if(annul_if), .annul_rf(annul_rf), .annul_alu(annul_alu)
    );

    // bench pipeline model
    ins_t s_rf, s_alu, s_mem, s_wb;
    logic v_rf, v_alu, v_mem, v_wb;
    int   pc, iter;
    logic e_stall, e_aif;

    function automatic ins_t mk(input int sa, sb, dst, input bit we, ld, br, input int tgt);
        ins_t r;
        r.sa = 5'(sa); r.sb = 5'(sb); r.dst = 5'(dst);
        r.we = we; r.ld = ld; r.br = br; r.tgt = 4'(tgt);
        return r;
    endfunction

    function automatic ins_t prog(input int p);
        case (p)
            0: return mk(31, 31, 1, 1, 0, 0, 0);  // index <- 0
            1: return mk(1, 31, 0, 1, 1, 0, 0);   // load element
            2: return mk(1, 31, 1, 1, 0, 0, 0);   // index += k
            3: return mk(0, 1, 2, 1, 0, 0, 0);    // compare
            4: return mk(2, 31, 31, 1, 0, 1, 1);  // branch back, link to zero
            5: return mk(1, 31, 3, 0, 0, 0, 0);   // store (delay slot)
            6: return mk(31, 31, 31, 0, 0, 1, 0); // jump to start
            default: return mk(31, 31, 31, 0, 0, 0, 0);
        endcase
    endfunction

    function automatic ins_t rnd_ins();
        int pick [5] = '{0, 1, 2, 3, 31};
        return mk(pick[$urandom_range(4)], pick[$urandom_range(4)], pick[$urandom_range(4)],
                  1'($urandom_range(3) != 0), 1'($urandom_range(2) == 0),
                  1'($urandom_range(5) == 0), 0);
    endfunction

    // expected select for one operand, with a tag naming the deciding rule
    function automatic void exp_op(input logic [4:0] src, output logic [1:0] sel,
                                   output logic haz, output string tag);
        bit ma, mm, mw, ga, gm;
        sel = 2'd0; haz = 1'b0; tag = "R1";
        if (src == 5'd31) begin tag = "R4"; return; end
        ga = (s_alu.we && s_alu.dst == src);
        gm = (s_mem.we && s_mem.dst == src);
        ma = v_alu && ga;
        mm = v_mem && gm;
        mw = v_wb && s_wb.we && s_wb.dst == src;
        if ((ga && !v_alu) || (gm && !v_mem)) tag = "R5";
        if (int'(ma) + int'(mm) + int'(mw) > 1) tag = "R2";
        if (ma) begin
            if (s_alu.ld) begin haz = 1'b1; tag = "R3"; end else sel = 2'd1;
        end else if (mm) begin
            if (s_mem.ld) begin haz = 1'b1; tag = "R3"; end else sel = 2'd2;
        end else if (mw) begin
            sel = 2'd3;
            if (s_wb.ld) tag = "R3";
        end
    endfunction

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0t act=%0d exp=%0d", tag, $time, act, exp);
        end
    endtask

    task automatic drive();
        rf_src_a = s_rf.sa;  rf_src_b = s_rf.sb;
        rf_br_taken = s_rf.br;
        alu_dst = s_alu.dst; alu_we = s_alu.we; alu_ld = s_alu.ld;
        mem_dst = s_mem.dst; mem_we = s_mem.we; mem_ld = s_mem.ld;
        wb_dst  = s_wb.dst;  wb_we  = s_wb.we;
    endtask

    task automatic check_cycle();
        logic [1:0] sa, sb;
        logic ha, hb;
        string ta, tb;
        exp_op(s_rf.sa, sa, ha, ta);
        exp_op(s_rf.sb, sb, hb, tb);
        e_stall = v_rf && (ha || hb);
        e_aif   = v_rf && s_rf.br && !e_stall;
        #3;
        chk({ta, " sel_a"}, fwd_sel_a, sa);
        chk({tb, " sel_b"}, fwd_sel_b, sb);
        chk((ha || hb) ? "R3 stall" : "R6 stall", {1'b0, stall}, {1'b0, e_stall});
        chk("R6 annul_rf", {1'b0, annul_rf}, {1'b0, e_stall});
        chk("R7 annul_if", {1'b0, annul_if}, {1'b0, e_aif});
        chk("R8 annul_alu", {1'b0, annul_alu}, 2'd0);
    endtask

    task automatic advance(input bit directed);
        ins_t f;
        if (directed) begin
            f = prog(pc);
            if (pc == 4) f.br = (iter < 2);
        end else begin
            f = rnd_ins();
        end
        s_wb = s_mem; v_wb = v_mem;
        s_mem = s_alu; v_mem = v_alu;
        s_alu = s_rf; v_alu = v_rf && !e_stall;
        if (!e_stall) begin
            if (e_aif) begin
                pc = int'(s_rf.tgt);
                if (s_rf.tgt == 4'd1) iter++;
                if (s_rf.tgt == 4'd0) iter = 0;
            end else begin
                pc = pc + 1;
            end
            s_rf = f; v_rf = !e_aif;
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        pc = 0; iter = 0;
        v_rf = 0; v_alu = 0; v_mem = 0; v_wb = 0;
        // garbage that would match everywhere if stages were treated as valid
        s_rf  = mk(1, 2, 0, 1, 0, 1, 0);
        s_alu = mk(9, 9, 1, 1, 1, 0, 0);
        s_mem = mk(9, 9, 2, 1, 0, 0, 0);
        s_wb  = mk(9, 9, 2, 1, 0, 0, 0);
        drive();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R9: reset state, nothing valid
        #2;
        chk("R9 sel_a after reset", fwd_sel_a, 2'd0);
        chk("R9 stall after reset", {1'b0, stall}, 2'd0);
        chk("R9 annul_if after reset", {1'b0, annul_if}, 2'd0);
        e_stall = 0; e_aif = 0;
        s_rf = prog(0);
        @(posedge clk); #1;
        pc = 1; v_rf = 1;
        // directed loop replay
        for (int c = 0; c < 40; c++) begin
            drive();
            check_cycle();
            @(posedge clk); #1;
            advance(1);
        end
        // random stream
        for (int c = 0; c < RAND_CYC; c++) begin
            drive();
            check_cycle();
            @(posedge clk); #1;
            advance(0);
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule